// File: doc/BRIEF.md
# Automatic Pause Frame Scheduler

This block sits between the arbiter that picks packets from a transmit FIFO and the MAC transmitter. While an external flow-control request is held high, it asks the transmitter to send MAC Control pause frames that carry a programmed pause time. The first of these frames goes out as soon as the transmitter has finished whatever frame it is sending. Ahead of it, no queued regular packet is released.

Once the transmitter accepts a pause frame, a refresh timer counts pause quanta. It is loaded with the programmed time reduced by a latency margin, so that a new frame goes out before the link partner's pause runs out. When the flow-control request is dropped, a closing frame with a pause time of zero is requested, unless that frame is disabled by configuration. A separate hold input covers pause frames received from the partner. That hold stops regular packets only and never stops the block's own pause frames.

Top module: `pause_frame_sched`

## Requirements
- R1: While reset is asserted, `pf_req` is low.
- R2: When `fc_req` rises with the transmitter idle, `pkt_grant` drops in that same cycle. From the next cycle on, `pf_req` is high and `pf_time` equals `cfg_pause_time`.
- R3: `pf_req` is never high while `tx_busy` is high, so a frame already on the wire finishes first. While a pause frame is waiting, `pkt_grant` stays low even when `pkt_ready` is high.
- R4: With `fc_req` held high and `cfg_pause_time` = P > LAT_ADJ, the next `pf_req` appears in the cycle after the (P − LAT_ADJ)-th `quanta_tick` that follows acceptance of the previous frame. It does not appear earlier.
- R5: With P ≤ LAT_ADJ, the refresh request appears in the cycle after the first `quanta_tick` that follows acceptance.
- R6: After `fc_req` falls and `cfg_end_pause_en` = 1, a frame with `pf_time` = 0 is requested once no pause frame is in flight.
- R7: With `cfg_end_pause_en` = 0, no frame with `pf_time` = 0 is requested when `fc_req` falls. The block goes back to idle.
- R8: `rx_pause_hold` forces `pkt_grant` low but does not delay or suppress `pf_req`.
- R9: When idle, or while the refresh timer is running with `fc_req` high, `pkt_grant` = `pkt_ready` && !`tx_busy` && !`rx_pause_hold`. It is never high in the same cycle as `pf_req`.
- R10: If `fc_req` falls while a pause frame is pending, that frame is still requested with `pf_time` = `cfg_pause_time`. The zero-time frame follows it.
- R11: Only one pause frame is outstanding at a time. After a cycle with `pf_req` && `pf_ack`, `pf_req` stays low until that frame's `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_req | input | 1 | Flow-control request; pause frames are generated while high |
| cfg_pause_time | input | TW | Pause time placed in frames, in quanta |
| cfg_end_pause_en | input | 1 | Enables the closing zero-time frame |
| rx_pause_hold | input | 1 | Inhibit for regular packets due to a received pause |
| quanta_tick | input | 1 | One-cycle pulse per pause quantum (512 bit times) |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_done | input | 1 | One-cycle pulse at the end of a transmitted frame |
| pkt_ready | input | 1 | A regular packet waits in the transmit FIFO |
| pf_ack | input | 1 | Transmitter accepts the requested pause frame |
| pf_req | output | 1 | Pause frame request |
| pf_time | output | TW | Pause time for the requested frame |
| pkt_grant | output | 1 | Permission to start the next regular packet |

## Verification
The bench builds the block with its default parameters: a 16-bit pause time and a 32-quantum latency margin. With programmed times of 40 and 20, both sides of the margin can be reached in a few ticks. A time of 40 leaves an 8-tick refresh interval that is counted one tick at a time. A time of 20 falls below the margin and exercises the immediate-refresh path. Ticks are driven by hand, so the exact tick that must raise the request can be checked against the ticks just before it.

// File: rtl/pause_frame_sched.sv
module pause_frame_sched #(
  parameter int TW      = 16,
  parameter int LAT_ADJ = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_req,
  input  logic [TW-1:0] cfg_pause_time,
  input  logic          cfg_end_pause_en,
  input  logic          rx_pause_hold,
  input  logic          quanta_tick,
  input  logic          tx_busy,
  input  logic          tx_done,
  input  logic          pkt_ready,
  input  logic          pf_ack,
  output logic          pf_req,
  output logic [TW-1:0] pf_time,
  output logic          pkt_grant
);

  localparam logic [TW-1:0] ADJ = TW'(LAT_ADJ);
  localparam logic [TW-1:0] ONE = TW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_SEND, S_WAIT, S_ZREQ, S_ZSEND
  } st_t;

  st_t           st, st_nx;
  logic [TW-1:0] cnt;
  logic          due;

  wire           accept     = pf_req && pf_ack;
  wire           timing     = (st == S_SEND) || (st == S_WAIT);
  wire           expire_now = quanta_tick && (cnt <= ONE);
  wire [TW-1:0]  load_val   = (cfg_pause_time > ADJ) ? cfg_pause_time - ADJ : '0;
  wire           grant_ok   = ((st == S_IDLE) && !fc_req) ||
                              ((st == S_WAIT) && fc_req && !expire_now);

  assign pf_req    = ((st == S_REQ) || (st == S_ZREQ)) && !tx_busy;
  assign pf_time   = (st == S_ZREQ) ? '0 : cfg_pause_time;
  assign pkt_grant = grant_ok && pkt_ready && !tx_busy && !rx_pause_hold;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (fc_req) st_nx = S_REQ;
      S_REQ:   if (accept) st_nx = S_SEND;
      S_SEND:
        if (tx_done) begin
          if (!fc_req)                 st_nx = cfg_end_pause_en ? S_ZREQ : S_IDLE;
          else if (due || expire_now)  st_nx = S_REQ;
          else                         st_nx = S_WAIT;
        end
      S_WAIT:
        if (!fc_req)         st_nx = cfg_end_pause_en ? S_ZREQ : S_IDLE;
        else if (expire_now) st_nx = S_REQ;
      S_ZREQ:  if (accept)  st_nx = S_ZSEND;
      S_ZSEND: if (tx_done) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      due <= 1'b0;
    end else begin
      st <= st_nx;
      if ((st == S_REQ) && accept)
        cnt <= load_val;
      else if (timing && quanta_tick && (cnt != '0))
        cnt <= cnt - ONE;
      if (st == S_SEND) begin
        if (expire_now) due <= 1'b1;
      end else begin
        due <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pause_frame_sched_chk.sv
module pause_frame_sched_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fc_req,
  input logic [TW-1:0] cfg_pause_time,
  input logic          cfg_end_pause_en,
  input logic          rx_pause_hold,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          pf_ack,
  input logic          pf_req,
  input logic [TW-1:0] pf_time,
  input logic          pkt_grant
);

  a_r1_no_req_in_reset: assert property (@(posedge clk)
    !rst_n |-> !pf_req);

  a_r3_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> !tx_busy);

  a_r8_hold_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_hold |-> !pkt_grant);

  a_r9_grant_excludes_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_req && pkt_grant));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req && pf_ack) |=> !pf_req);

  a_r7_no_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_end_pause_en && cfg_pause_time != '0) |-> !(pf_req && pf_time == '0));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req && !pf_ack) |=> (pf_req || tx_busy));

endmodule

bind pause_frame_sched pause_frame_sched_chk #(.TW(TW)) i_chk (.*);

// File: tb/test_pause_frame_sched.sv
module test_pause_frame_sched;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fc_req = 1'b0;
  logic [TW-1:0] cfg_pause_time = 16'd40;
  logic          cfg_end_pause_en = 1'b1;
  logic          rx_pause_hold = 1'b0;
  logic          quanta_tick = 1'b0;
  logic          tx_busy = 1'b0;
  logic          tx_done = 1'b0;
  logic          pkt_ready = 1'b0;
  logic          pf_ack = 1'b0;
  logic          pf_req;
  logic [TW-1:0] pf_time;
  logic          pkt_grant;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  pause_frame_sched #(.TW(TW), .LAT_ADJ(32)) i_pause_frame_sched (.*);

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    quanta_tick = 1'b1; cyc(); quanta_tick = 1'b0;
  endtask

  task automatic send_frame(input string tag);
    pf_ack = 1'b1; cyc();
    pf_ack = 1'b0; tx_busy = 1'b1;
    chk({tag, " R11 req low after accept"}, pf_req, 0);
    cyc(); cyc();
    chk({tag, " R11 req low in flight"}, pf_req, 0);
    tx_busy = 1'b0; tx_done = 1'b1; cyc();
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    cyc(); cyc();
    chk("R1 req low in reset", pf_req, 0);
    rst_n = 1'b1; cyc();
    pkt_ready = 1'b1; #1;
    chk("R9 grant when idle", pkt_grant, 1);
    pkt_ready = 1'b0;
  endtask

  task automatic t_basic();
    cfg_pause_time = 16'd40; cfg_end_pause_en = 1'b1; pkt_ready = 1'b1;
    fc_req = 1'b1; #1;
    chk("R2 grant blocked on request", pkt_grant, 0);
    cyc();
    chk("R2 req raised", pf_req, 1);
    chk("R2 req time", pf_time, 40);
    chk("R3 grant low while pending", pkt_grant, 0);
    send_frame("basic");
    chk("R9 grant while timer runs", pkt_grant, 1);
    for (int i = 0; i < 7; i++) begin
      tick(); cyc();
      chk("R4 no early refresh", pf_req, 0);
    end
    tick();
    chk("R4 refresh after 8 ticks", pf_req, 1);
    chk("R4 refresh time", pf_time, 40);
    fc_req = 1'b0; cyc();
    chk("R10 pending kept on release", pf_req, 1);
    chk("R10 pending time", pf_time, 40);
    send_frame("release");
    chk("R6 zero frame requested", pf_req, 1);
    chk("R6 zero frame time", pf_time, 0);
    send_frame("zero");
    chk("R6 idle after zero frame", pf_req, 0);
    chk("R9 grant back after zero frame", pkt_grant, 1);
    pkt_ready = 1'b0;
  endtask

  task automatic t_short();
    cfg_pause_time = 16'd20; cfg_end_pause_en = 1'b0;
    fc_req = 1'b1; cyc();
    chk("R5 first req", pf_req, 1);
    send_frame("short");
    cyc(); cyc();
    chk("R5 no refresh without tick", pf_req, 0);
    tick();
    chk("R5 refresh on first tick", pf_req, 1);
    chk("R5 refresh time", pf_time, 20);
    send_frame("short2");
    fc_req = 1'b0; cyc(); cyc();
    chk("R7 no zero frame", pf_req, 0);
    pkt_ready = 1'b1; #1;
    chk("R7 back to idle grant", pkt_grant, 1);
    pkt_ready = 1'b0;
    cfg_end_pause_en = 1'b1;
  endtask

  task automatic t_busy();
    cfg_pause_time = 16'd40;
    tx_busy = 1'b1; pkt_ready = 1'b1;
    fc_req = 1'b1; cyc(); cyc(); cyc();
    chk("R3 req waits for busy", pf_req, 0);
    tx_busy = 1'b0; tx_done = 1'b1; #1;
    chk("R3 req after frame end", pf_req, 1);
    chk("R3 grant low while pending", pkt_grant, 0);
    cyc(); tx_done = 1'b0;
    send_frame("busy");
    fc_req = 1'b0; cyc();
    chk("R6 zero frame from timer wait", pf_req, 1);
    chk("R6 zero time from timer wait", pf_time, 0);
    send_frame("busyz");
    pkt_ready = 1'b0;
  endtask

  task automatic t_hold();
    rx_pause_hold = 1'b1; pkt_ready = 1'b1; #1;
    chk("R8 hold blocks grant", pkt_grant, 0);
    fc_req = 1'b1; cyc();
    chk("R8 hold does not block pause", pf_req, 1);
    fc_req = 1'b0;
    send_frame("hold");
    chk("R8 zero frame under hold", pf_req, 1);
    send_frame("holdz");
    rx_pause_hold = 1'b0; #1;
    chk("R9 grant after hold release", pkt_grant, 1);
    pkt_ready = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_short();
    t_busy();
    t_hold();
    cyc();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule